// File: doc/BRIEF.md
# Half-Bridge Gate Command Interlock with Dead Time

This block sits between a PWM generator and the gate drivers of one half-bridge leg. It takes two switching commands, one for the upper switch (active high) and one for the lower switch (active low), plus an active-low stop input. It produces two active-high gate-enable outputs. All three inputs pass through a two-flop synchronizer before they are decoded.

The block never lets both switches conduct at once. Conflicting commands turn both gates off. Whenever a gate turns off, a single dead-time counter restarts, and no gate may turn on until that counter has run out. This holds when the two command edges fall in the same cycle, and when a gate is re-requested on the same side. A request that arrives after the counter has expired passes straight through. The dead time is the parameter `DEAD_CYCLES`, counted in clock cycles. Reset preloads the counter, so the first turn-on after reset also waits out the dead time.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, both gates are low. After `rst_n` rises with a gate already requested, that gate rises exactly `DEAD_CYCLES`+1 clock edges after the first edge with `rst_n` high.
- R2: When the synchronized `halt_n` is low, both gates go low and stay low, whatever the commands are. After `halt_n` returns high with the counter expired, a pending request reaches its gate on the third clock edge.
- R3: `hi_cmd`=1 together with `lo_cmd_n`=0 (both commands active) drives both gates low.
- R4: `hi_cmd`=0 together with `lo_cmd_n`=1 (no command active) drives both gates low.
- R5: `hi_cmd`=0 with `lo_cmd_n`=0 drives only `lo_gate` high. `hi_cmd`=1 with `lo_cmd_n`=1 drives only `hi_gate` high.
- R6: `lo_gate` and `hi_gate` are never high in the same cycle.
- R7: After either gate falls, no gate rises before `DEAD_CYCLES`+1 clock edges have passed, counted from the falling edge. A request that is already waiting is granted at exactly that edge, whether it is for the same side or the opposite side.
- R8: A request that arrives after the dead time has expired reaches its gate on the third clock edge after the input changes: two synchronizer stages and one output register.
- R9: Releasing one command and asserting the other in the same cycle still inserts the full dead time of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_cmd | input | 1 | Upper-switch command, active high |
| lo_cmd_n | input | 1 | Lower-switch command, active low |
| halt_n | input | 1 | Stop input, active low; forces both gates off |
| lo_gate | output | 1 | Lower-switch gate enable |
| hi_gate | output | 1 | Upper-switch gate enable |

## Verification
The hardest case to reach from the ports is a turn-on request that lands inside a running dead-time window. The bench must place a command change a known number of edges after a gate fell, and the three-stage input latency has to be counted into that offset. The stimulus schedules four such cases: a synchronous swap, an opposite-side request arriving a few cycles into the window, a same-side release-and-reassert, and a gap longer than the window. The expected rise edge for each case is computed from `DEAD_CYCLES` and the pipeline depth. Separate monitors check that the two gates never overlap and that every rise follows the last fall by the full idle count.

// File: rtl/hb_pkg.sv
// Package: hb_pkg
// Shared types for the half-bridge gate command logic.
// Assumes one leg per instance; the request code is internal only.
package hb_pkg;

    // Decoded leg request after synchronization and polarity handling.
    typedef enum logic [1:0] {
        REQ_OFF  = 2'd0,
        REQ_LOW  = 2'd1,
        REQ_HIGH = 2'd2
    } leg_req_e;

endpackage

// File: rtl/hb_sync.sv
// Module: hb_sync
// Two-flop synchronizer for a vector of asynchronous inputs.
// Each bit resets to its own value from RST_VAL, so that every
// signal starts from its safe, inactive state.
// Assumes inputs are level signals held for several clock cycles.
module hb_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic meta_q;
            logic stable_q;

            // Two-stage capture of one input bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q   <= RST_VAL[i];
                    stable_q <= RST_VAL[i];
                end else begin
                    meta_q   <= d[i];
                    stable_q <= meta_q;
                end
            end

            assign q[i] = stable_q;
        end
    endgenerate

endmodule

// File: rtl/hb_decode.sv
// Module: hb_decode
// Combinational decode of the synchronized commands into a leg request.
// The upper command is active high and the lower command is active low.
// A stop, conflicting commands, or no command all map to REQ_OFF.
module hb_decode
    import hb_pkg::*;
(
    input  logic     hi_on,
    input  logic     lo_on_n,
    input  logic     run_n,
    output leg_req_e req
);

    logic hi_act;
    logic lo_act;

    assign hi_act = hi_on;
    assign lo_act = !lo_on_n;

    // Priority: stop first, then interlock, then single-side request.
    always_comb begin
        if (!run_n) begin
            req = REQ_OFF;
        end else if (hi_act && lo_act) begin
            req = REQ_OFF;
        end else if (lo_act) begin
            req = REQ_LOW;
        end else if (hi_act) begin
            req = REQ_HIGH;
        end else begin
            req = REQ_OFF;
        end
    end

endmodule

// File: rtl/hb_deadtime.sv
// Module: hb_deadtime
// Registered gate outputs with a single shared dead-time counter.
// Any gate turning off reloads the counter to DEAD_CYCLES. While both
// gates are off the counter counts down, and a turn-on is granted only
// once it has reached zero. Reset preloads the counter.
// Assumes DEAD_CYCLES >= 1.
module hb_deadtime
    import hb_pkg::*;
#(
    parameter int DEAD_CYCLES = 18
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_e req,
    output logic     lo_gate,
    output logic     hi_gate
);

    localparam int CW  = $clog2(DEAD_CYCLES + 1);
    localparam int IW  = $clog2(DEAD_CYCLES + 2);
    localparam logic [CW-1:0] CNT_LOAD = CW'(DEAD_CYCLES);
    localparam logic [IW-1:0] IDLE_MAX = IW'(DEAD_CYCLES + 1);

    logic [CW-1:0] wait_cnt;
    logic          lo_q;
    logic          hi_q;

    // Gate state and dead-time counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= 1'b0;
            hi_q     <= 1'b0;
            wait_cnt <= CNT_LOAD;
        end else if (lo_q && req != REQ_LOW) begin
            lo_q     <= 1'b0;
            wait_cnt <= CNT_LOAD;
        end else if (hi_q && req != REQ_HIGH) begin
            hi_q     <= 1'b0;
            wait_cnt <= CNT_LOAD;
        end else if (!lo_q && !hi_q) begin
            if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - 1'b1;
            end else if (req == REQ_LOW) begin
                lo_q <= 1'b1;
            end else if (req == REQ_HIGH) begin
                hi_q <= 1'b1;
            end
        end
    end

    assign lo_gate = lo_q;
    assign hi_gate = hi_q;

    // Independent idle tracker used only by the assertions below.
    logic [IW-1:0] idle_chk;

    // Counts edges with both gates off, saturating at DEAD_CYCLES+1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_chk <= '0;
        end else if (lo_q || hi_q) begin
            idle_chk <= '0;
        end else if (idle_chk != IDLE_MAX) begin
            idle_chk <= idle_chk + 1'b1;
        end
    end

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_q && hi_q));

    assert_lo_rise_after_dead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_q) |-> (idle_chk == IDLE_MAX));

    assert_hi_rise_after_dead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> (idle_chk == IDLE_MAX));

endmodule

// File: rtl/hb_gate_ctrl.sv
// Module: hb_gate_ctrl
// Top of the half-bridge command interlock. The three inputs are
// synchronized, decoded into a single leg request, and passed to the
// dead-time stage, which owns the gate registers.
// Assumes inputs are asynchronous to clk and DEAD_CYCLES >= 1.
module hb_gate_ctrl
    import hb_pkg::*;
#(
    parameter int DEAD_CYCLES = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd_n,
    input  logic halt_n,
    output logic lo_gate,
    output logic hi_gate
);

    // Bit order in the synchronizer: {halt_n, lo_cmd_n, hi_cmd}.
    localparam int NSYNC = 3;
    localparam logic [NSYNC-1:0] SYNC_RST = 3'b010;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] sync_in;
    leg_req_e         req;

    assign raw_in = {halt_n, lo_cmd_n, hi_cmd};

    hb_sync #(
        .WIDTH   (NSYNC),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    hb_decode u_decode (
        .hi_on   (sync_in[0]),
        .lo_on_n (sync_in[1]),
        .run_n   (sync_in[2]),
        .req     (req)
    );

    hb_deadtime #(
        .DEAD_CYCLES (DEAD_CYCLES)
    ) u_dead (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .lo_gate (lo_gate),
        .hi_gate (hi_gate)
    );

    assert_reset_off_R1: assert property (@(posedge clk)
        !rst_n |=> (!lo_gate && !hi_gate));

    assert_halt_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_in[2] |=> (!lo_gate && !hi_gate));

    assert_interlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in[0] && !sync_in[1]) |=> (!lo_gate && !hi_gate));

    assert_idle_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_in[0] && sync_in[1]) |=> (!lo_gate && !hi_gate));

    assert_lo_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_gate |-> $past(sync_in[2] && !sync_in[1] && !sync_in[0]));

endmodule

// File: tb/hb_gate_ctrl_test.sv
// Scoreboard bench: driver tasks push expected gate states, and a
// monitor pops and compares them 2 ns after each rising clock edge.
module hb_gate_ctrl_test;

    localparam int D = 18;

    typedef struct {
        logic  lo;
        logic  hi;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 1'b0;
    logic lo_cmd_n = 1'b1;
    logic halt_n = 1'b1;
    logic lo_gate;
    logic hi_gate;

    int checks = 0;
    int errors = 0;
    int overlap_errs = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    hb_gate_ctrl #(.DEAD_CYCLES(D)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_cmd   (hi_cmd),
        .lo_cmd_n (lo_cmd_n),
        .halt_n   (halt_n),
        .lo_gate  (lo_gate),
        .hi_gate  (hi_gate)
    );

    task automatic drive(input logic h, input logic ln, input logic rn);
        @(negedge clk);
        hi_cmd   = h;
        lo_cmd_n = ln;
        halt_n   = rn;
    endtask

    task automatic expect_after(input int n, input logic lo, input logic hi, input string tag);
        exp_t it;
        repeat (n) @(posedge clk);
        it.lo  = lo;
        it.hi  = hi;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: scoreboard compare, overlap check, dead-time check.
    logic prev_lo = 1'b0;
    logic prev_hi = 1'b0;
    int   since = 0;
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                checks++;
                if (lo_gate !== it.lo || hi_gate !== it.hi) begin
                    errors++;
                    $display("FAIL %s: lo=%b hi=%b expected lo=%b hi=%b",
                             it.tag, lo_gate, hi_gate, it.lo, it.hi);
                end
            end
            if (lo_gate === 1'b1 && hi_gate === 1'b1) begin
                overlap_errs++;
                $display("FAIL R6: lo=1 hi=1 expected not both high");
            end
            if (!rst_n) begin
                since = 0;
            end else begin
                if ((prev_lo && !lo_gate) || (prev_hi && !hi_gate)) since = 0;
                else if (since < 1000) since++;
                if ((!prev_lo && lo_gate) || (!prev_hi && hi_gate)) begin
                    checks++;
                    if (since < D + 1) begin
                        errors++;
                        $display("FAIL R7: rise after %0d idle edges expected >= %0d",
                                 since, D + 1);
                    end
                end
            end
            prev_lo = lo_gate;
            prev_hi = hi_gate;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset holds both low; the first turn-on waits out the dead time.
        expect_after(4, 1'b0, 1'b0, "R1 reset");
        @(negedge clk);
        rst_n    = 1'b1;
        lo_cmd_n = 1'b0;
        expect_after(D, 1'b0, 1'b0, "R1 preload wait");
        expect_after(1, 1'b1, 1'b0, "R1/R5 first low turn-on");
        expect_after(5, 1'b1, 1'b0, "R5 low held");

        // R9: synchronous swap from low to high.
        drive(1'b1, 1'b1, 1'b1);
        expect_after(2, 1'b1, 1'b0, "R9 before sync");
        expect_after(1, 1'b0, 1'b0, "R9 low off");
        expect_after(D, 1'b0, 1'b0, "R9 dead window");
        expect_after(1, 1'b0, 1'b1, "R9/R5 high on");

        // R3: overlapping commands trigger the interlock.
        drive(1'b1, 1'b0, 1'b1);
        expect_after(3, 1'b0, 1'b0, "R3 interlock");
        expect_after(30, 1'b0, 1'b0, "R3 interlock held");
        // R8: dead time already expired, so the request passes through.
        drive(1'b0, 1'b0, 1'b1);
        expect_after(2, 1'b0, 1'b0, "R8 latency");
        expect_after(1, 1'b1, 1'b0, "R8 pass-through low");

        // R4 off, then R7: the high request lands inside the window.
        drive(1'b0, 1'b1, 1'b1);
        expect_after(3, 1'b0, 1'b0, "R4 no command");
        expect_after(5, 1'b0, 1'b0, "R4 held");
        drive(1'b1, 1'b1, 1'b1);
        expect_after(13, 1'b0, 1'b0, "R7 delayed turn-on");
        expect_after(1, 1'b0, 1'b1, "R7 high granted");

        // R2: halt overrides every command pattern.
        drive(1'b1, 1'b1, 1'b0);
        expect_after(3, 1'b0, 1'b0, "R2 halt high");
        drive(1'b0, 1'b0, 1'b0);
        expect_after(30, 1'b0, 1'b0, "R2 halt low req");
        drive(1'b1, 1'b1, 1'b0);
        expect_after(5, 1'b0, 1'b0, "R2 halt high req");
        drive(1'b1, 1'b1, 1'b1);
        expect_after(2, 1'b0, 1'b0, "R2 release latency");
        expect_after(1, 1'b0, 1'b1, "R2 release high on");

        // R8: gap longer than the dead time passes straight through.
        drive(1'b0, 1'b1, 1'b1);
        expect_after(3, 1'b0, 1'b0, "R4 high off");
        expect_after(D + 10, 1'b0, 1'b0, "R8 long gap");
        drive(1'b0, 1'b0, 1'b1);
        expect_after(2, 1'b0, 1'b0, "R8 gap latency");
        expect_after(1, 1'b1, 1'b0, "R8 low direct");

        // R7: a same-side release and reassert also waits out the dead time.
        drive(1'b0, 1'b1, 1'b1);
        expect_after(2, 1'b1, 1'b0, "R7 still on");
        drive(1'b0, 1'b0, 1'b1);
        expect_after(1, 1'b0, 1'b0, "R7 low off");
        expect_after(D, 1'b0, 1'b0, "R7 same-side window");
        expect_after(1, 1'b1, 1'b0, "R7 same-side on");

        repeat (3) @(posedge clk);
        #3;
        checks++;
        if (overlap_errs != 0) begin
            errors++;
            $display("FAIL R6: overlap cycles=%0d expected 0", overlap_errs);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule